// File: doc/BRIEF.md
# Low-Power Residency Histogram Counter

This block measures how long a cluster cache stays in each low-power episode and keeps a three-bin histogram of those durations. While the low-power-active level is high, a tenure counter advances once per cycle of the fixed crystal reference clock. When the level drops, the finished tenure is compared against two programmable inclusive upper bounds. The matching low, mid or high occurrence counter is then incremented, and the tenure counter returns to zero for the next episode.

There is one instance per cluster. The running tenure and the three occurrence counts are visible on output ports. An occurrence counter that wraps sets a sticky flag, and that flag drives a level-high interrupt. The flag clears only on reset. Crossing from other clock domains and power sequencing are handled outside this block.

Top module: `lp_residency_hist`

## Requirements
- R1: While `lp_active_i` is sampled high on a rising edge of `clk_i`, `tenure_o` increases by one at that edge (unless saturated). An episode sampled high on L edges therefore shows `tenure_o` = L once it ends.
- R2: On the first edge where `lp_active_i` is sampled low and `tenure_o` is non-zero, the episode is classified and `tenure_o` returns to 0 at that same edge.
- R3: `tenure_o` saturates at its all-ones value (2^TENURE_W-1) instead of wrapping. A saturated episode is classified using that maximum value.
- R4: A finished tenure t with 0 < t <= `thr_low_i` increments `cnt_low_o`.
- R5: A finished tenure t with `thr_low_i` < t <= `thr_mid_i` increments `cnt_mid_o`.
- R6: A finished tenure t > `thr_mid_i` and t > `thr_low_i` increments `cnt_high_o`. When `thr_low_i` exceeds `thr_mid_i`, every tenure above `thr_low_i` goes to the high bin.
- R7: Each finished episode increments exactly one occurrence counter, and the other two hold their values.
- R8: Occurrence counters are OCC_W bits wide and wrap from all-ones to 0. Any wrap sets `irq_o` high, and `irq_o` stays high until `rst_ni` is asserted.
- R9: While `rst_ni` is low, `tenure_o`, all three occurrence counters and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lp_active_i | input | 1 | High while the cache is in low-power mode |
| thr_low_i | input | TENURE_W | Inclusive upper bound of the low bin |
| thr_mid_i | input | TENURE_W | Inclusive upper bound of the mid bin |
| tenure_o | output | TENURE_W | Running tenure of the current episode |
| cnt_low_o | output | OCC_W | Low-bin occurrence count |
| cnt_mid_o | output | OCC_W | Mid-bin occurrence count |
| cnt_high_o | output | OCC_W | High-bin occurrence count |
| irq_o | output | 1 | Sticky occurrence-counter overflow interrupt |

## Verification
The bench builds the block with TENURE_W = 4 and OCC_W = 4. With these widths the tenure counter saturates at 15 and each occurrence counter wraps after 16 events, so both saturation and the interrupt are reached within a short run. Every pair of thresholds from 0 to 15 is combined with episode lengths 1 to 17. This covers empty bins at threshold 0, equal thresholds, inverted thresholds and episodes past saturation, and each result is checked against an arithmetic bin model.

// File: rtl/lprh_pkg.sv
package lprh_pkg;
  localparam int unsigned NUM_BINS = 3;
  typedef enum logic [1:0] {
    BIN_LOW  = 2'd0,
    BIN_MID  = 2'd1,
    BIN_HIGH = 2'd2
  } bin_e;
endpackage

// File: rtl/lprh_tenure_ctr.sv
module lprh_tenure_ctr #(
  parameter int unsigned TENURE_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lp_active_i,
  output logic [TENURE_W-1:0] tenure_o,
  output logic                done_o
);
  localparam logic [TENURE_W-1:0] TMAX = '1;

  logic [TENURE_W-1:0] tenure_q;

  // episode ends on first low sample after a non-zero tenure
  assign done_o   = !lp_active_i && (tenure_q != '0);
  assign tenure_o = tenure_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  tenure_q <= '0;
    else if (lp_active_i) begin
      if (tenure_q != TMAX)       tenure_q <= tenure_q + 1'b1;
    end else if (done_o)          tenure_q <= '0;
  end

  AST_TENURE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_active_i && tenure_q != TMAX) |=> (tenure_q == $past(tenure_q) + 1'b1)); // R1
  AST_TENURE_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_active_i && tenure_q == TMAX) |=> (tenure_q == TMAX)); // R3
  AST_END_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lp_active_i) |=> (tenure_q == '0)); // R2
endmodule

// File: rtl/lprh_classify.sv
module lprh_classify
  import lprh_pkg::*;
#(
  parameter int unsigned TENURE_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [TENURE_W-1:0] tenure_i,
  input  logic [TENURE_W-1:0] thr_low_i,
  input  logic [TENURE_W-1:0] thr_mid_i,
  output logic [NUM_BINS-1:0] inc_o
);
  bin_e bin;

  // inclusive upper bounds; inverted thresholds fall through to high
  always_comb begin
    if (tenure_i <= thr_low_i)      bin = BIN_LOW;
    else if (tenure_i <= thr_mid_i) bin = BIN_MID;
    else                            bin = BIN_HIGH;
  end

  always_comb begin
    inc_o = '0;
    if (valid_i && tenure_i != '0) inc_o[bin] = 1'b1;
  end

  AST_ONE_BIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(inc_o)); // R7
  AST_BIN_ON_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && tenure_i != '0) |-> ($countones(inc_o) == 1)); // R7
  AST_INVERTED_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && thr_low_i > thr_mid_i && tenure_i > thr_low_i) |-> inc_o[BIN_HIGH]); // R6
endmodule

// File: rtl/lprh_occ_ctr.sv
module lprh_occ_ctr #(
  parameter int unsigned OCC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [OCC_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [OCC_W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  AST_OCC_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> (cnt_q == $past(cnt_q) + 1'b1)); // R8
  AST_OCC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/lp_residency_hist.sv
module lp_residency_hist
  import lprh_pkg::*;
#(
  parameter int unsigned TENURE_W = 32,
  parameter int unsigned OCC_W    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lp_active_i,
  input  logic [TENURE_W-1:0] thr_low_i,
  input  logic [TENURE_W-1:0] thr_mid_i,
  output logic [TENURE_W-1:0] tenure_o,
  output logic [OCC_W-1:0]    cnt_low_o,
  output logic [OCC_W-1:0]    cnt_mid_o,
  output logic [OCC_W-1:0]    cnt_high_o,
  output logic                irq_o
);
  logic                done;
  logic [NUM_BINS-1:0] inc;
  logic [NUM_BINS-1:0] wrap;
  logic [OCC_W-1:0]    cnt [NUM_BINS];
  logic                ovf_q;

  lprh_tenure_ctr #(.TENURE_W(TENURE_W)) u_tenure (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lp_active_i (lp_active_i),
    .tenure_o    (tenure_o),
    .done_o      (done)
  );

  lprh_classify #(.TENURE_W(TENURE_W)) u_classify (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (done),
    .tenure_i  (tenure_o),
    .thr_low_i (thr_low_i),
    .thr_mid_i (thr_mid_i),
    .inc_o     (inc)
  );

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    lprh_occ_ctr #(.OCC_W(OCC_W)) u_occ (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[b]),
      .cnt_o  (cnt[b]),
      .wrap_o (wrap[b])
    );
  end

  assign cnt_low_o  = cnt[BIN_LOW];
  assign cnt_mid_o  = cnt[BIN_MID];
  assign cnt_high_o = cnt[BIN_HIGH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ovf_q <= 1'b0;
    else if (|wrap) ovf_q <= 1'b1;
  end

  assign irq_o = ovf_q;

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> irq_o); // R8
  AST_IRQ_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wrap) |=> irq_o); // R8
endmodule

// File: tb/sim_lp_residency_hist.sv
module sim_lp_residency_hist;
  localparam int unsigned TW = 4;
  localparam int unsigned CW = 4;
  localparam int CLK_PERIOD = 10;
  localparam int TMAX = (1 << TW) - 1;
  localparam int CMOD = 1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp = 1'b0;
  logic [TW-1:0] thr_lo = '0, thr_mi = '0;
  logic [TW-1:0] tenure;
  logic [CW-1:0] c_lo, c_mi, c_hi;
  logic irq;

  int n_tests = 0, n_fail = 0;
  int m_lo = 0, m_mi = 0, m_hi = 0;
  bit m_ovf = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_residency_hist #(.TENURE_W(TW), .OCC_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .lp_active_i(lp),
    .thr_low_i(thr_lo), .thr_mid_i(thr_mi),
    .tenure_o(tenure), .cnt_low_o(c_lo), .cnt_mid_o(c_mi),
    .cnt_high_o(c_hi), .irq_o(irq)
  );

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " cnt_low"},  int'(c_lo), m_lo);
    chk({req, " cnt_mid"},  int'(c_mi), m_mi);
    chk({req, " cnt_high"}, int'(c_hi), m_hi);
    chk({req, " irq"},      int'(irq),  int'(m_ovf));
  endtask

  task automatic bump(ref int c);
    if (c == CMOD - 1) begin c = 0; m_ovf = 1; end
    else c = c + 1;
  endtask

  // drive lp high for len edges, then low; inputs change at negedge
  task automatic episode(int len, int lo, int mi);
    int t;
    thr_lo = TW'(lo);
    thr_mi = TW'(mi);
    lp = 1'b1;
    repeat (len) @(negedge clk);
    t = (len > TMAX) ? TMAX : len;
    chk(len > TMAX ? "R3 saturated tenure" : "R1 tenure count", int'(tenure), t);
    lp = 1'b0;
    @(negedge clk);
    chk("R2 tenure cleared after end", int'(tenure), 0);
    if (t <= lo)      bump(m_lo);   // R4
    else if (t <= mi) bump(m_mi);   // R5
    else              bump(m_hi);   // R6
    chk_all("R4/R5/R6/R7/R8 bins");
  endtask

  initial begin
    #(CLK_PERIOD * 120000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9 reset tenure", int'(tenure), 0);
    chk_all("R9 reset");
    lp = 1'b1;
    @(negedge clk);
    chk("R9 tenure held in reset", int'(tenure), 0);
    lp = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle tenure", int'(tenure), 0);
    chk_all("R7 idle no increment");

    for (int lo = 0; lo <= TMAX; lo++)
      for (int mi = 0; mi <= TMAX; mi++)
        for (int len = 1; len <= TMAX + 2; len++)
          episode(len, lo, mi);

    // R8 interrupt cleared only by reset
    chk("R8 irq set after wraps", int'(irq), 1);
    rst_n = 1'b0;
    @(negedge clk);
    m_lo = 0; m_mi = 0; m_hi = 0; m_ovf = 0;
    chk("R9 second reset tenure", int'(tenure), 0);
    chk_all("R8/R9 cleared by reset");
    rst_n = 1'b1;
    @(negedge clk);
    episode(3, 5, 9);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    done = 1;
    $finish;
  end
endmodule